// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures a bank of interrupt input lines into a request register, one pending bit per line. A trigger-select register picks, per line, whether the line is sensed by level or by rising edge. In level mode the pending bit tracks the input. In edge mode a stored copy of the previous input level lets the block catch low-to-high transitions. A request caught that way stays pending until the acknowledge logic clears it.

Writes to the trigger-select register pass through a fixed per-instance writable mask. Bits outside the mask can never be set, so the lines they cover stay in edge mode. Acknowledge strobes are per line and clear only edge-mode requests. A reinitialization strobe drops edge-mode requests and the previous-level memory, and keeps level-mode requests. Each line also has a one-cycle "newly latched" flag for a pending bit that has just gone from 0 to 1. The flag is suppressed when that line is masked.

All inputs are sampled on the rising clock edge. Every output is registered and changes one cycle after the inputs that cause it.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pend`, `fresh` and `trig_sel` all become zero after that edge, which puts every line in edge mode.
- R2: When `trig_wr` is high, `trig_sel` becomes `trig_wdata & WR_MASK` after the edge. Bits outside `WR_MASK` always read 0. The default `WR_MASK` is 0xF8. `trig_sel[i]`=1 selects level mode for line i and 0 selects edge mode.
- R3: For a level-mode line, when `reinit` is low, `pend[i]` after an edge equals `req[i]` sampled at that edge. It is set while the input is high and cleared once the input is low.
- R4: For an edge-mode line, `pend[i]` is set when `req[i]` is 1 at an edge and was 0 at the previous edge. An input held high does not set the bit again after it has been cleared.
- R5: For an edge-mode line, a falling or low input does not clear a pending bit.
- R6: For an edge-mode line, `ack[i]` high clears `pend[i]` after the edge. A rising edge on the same cycle wins, and the bit stays set.
- R7: `ack[i]` has no effect on a level-mode line's pending bit.
- R8: With `reinit` high, edge-mode pending bits clear, level-mode pending bits keep their value, and the previous-level memory clears. A line held high through `reinit` therefore counts as a new edge on the following cycle.
- R9: `fresh[i]` is high for exactly the cycle in which `pend[i]` has just changed from 0 to 1, provided the line was not masked.
- R10: If `line_mask[i]` is high on the edge where `pend[i]` rises, `fresh[i]` stays 0 even though `pend[i]` sets.
- R11: With `trig_wr` low, `trig_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_LINES | Interrupt request input lines |
| trig_wr | input | 1 | Write strobe for the trigger-select register |
| trig_wdata | input | NUM_LINES | Trigger-select write data (1 = level mode) |
| ack | input | NUM_LINES | Per-line acknowledge clear strobe |
| reinit | input | 1 | Reinitialization strobe |
| line_mask | input | NUM_LINES | Per-line mask; suppresses the newly-latched flag |
| pend | output | NUM_LINES | Interrupt request register |
| fresh | output | NUM_LINES | One-cycle newly-latched flag per line |
| trig_sel | output | NUM_LINES | Current trigger-select register |

## Verification
The hardest state to reach from the ports is an edge-mode line whose input has been held high across a reinitialization. To get there, the stimulus raises the line, leaves it high, pulses `reinit`, and then keeps the input high. The bench expects the pending bit to drop on the reinit cycle and come back one cycle later, because the cleared previous-level memory now sees a fresh edge. A second hard case is an acknowledge that lands on the same edge as a new rising transition. The stimulus first lets the input fall after a latch, then drives it high again together with `ack`.

// File: rtl/irq_req_latch_pkg.sv
// Package: shared constants for the interrupt request latch.
// Assumes the bank width is a small power-of-two-free count (any >= 1).
package irq_req_latch_pkg;
    // Default number of request lines per bank.
    localparam int unsigned DEF_LINES = 8;
    // Default writable mask of the trigger-select register.
    localparam logic [DEF_LINES-1:0] DEF_WR_MASK = 8'hF8;
endpackage

// File: rtl/irq_trig_reg.sv
// Module: trigger-select register with a fixed writable mask.
// Assumes writes are single-cycle strobes; bits outside WR_MASK stay zero.
module irq_trig_reg #(
    parameter int unsigned NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WR_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] sel
);

    logic [NUM_LINES-1:0] sel_q;

    // Hold the masked trigger-select value; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr) begin
            sel_q <= wdata & WR_MASK;
        end
    end

    assign sel = sel_q;

    // R2
    outside_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q & ~WR_MASK) == '0);

    // R11
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(sel_q));

endmodule

// File: rtl/irq_line_cell.sv
// Module: one request line: previous-level memory, pending bit and
// newly-latched flag. Assumes level_mode, ack and reinit are sampled at the
// same edge as req; all outputs are registered.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic req,
    input  logic ack,
    input  logic reinit,
    input  logic masked,
    output logic pend,
    output logic fresh
);

    logic prev_q;
    logic pend_q;
    logic fresh_q;
    logic rise;
    logic pend_nxt;
    logic prev_nxt;

    // Rising transition seen against the previous sampled level.
    assign rise = req & ~prev_q;

    // Next pending value and previous-level memory from mode and strobes.
    always_comb begin
        if (reinit) begin
            pend_nxt = level_mode & pend_q;
            prev_nxt = 1'b0;
        end else if (level_mode) begin
            pend_nxt = req;
            prev_nxt = req;
        end else begin
            pend_nxt = rise | (pend_q & ~ack);
            prev_nxt = req;
        end
    end

    // Register the line state and the newly-latched flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            prev_q  <= prev_nxt;
            pend_q  <= pend_nxt;
            fresh_q <= pend_nxt & ~pend_q & ~masked;
        end
    end

    assign pend  = pend_q;
    assign fresh = fresh_q;

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !reinit) |=> (pend_q == $past(req)));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !reinit && !ack && pend_q) |=> pend_q);

    // R7
    level_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !reinit && ack && req) |=> pend_q);

    // R8
    reinit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && !level_mode) |=> (!pend_q && !prev_q));

    // R9
    fresh_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_q |-> pend_q);

    // R10
    masked_no_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        masked |=> !fresh_q);

endmodule

// File: rtl/irq_req_latch.sv
// Module: bank of request lines with a masked trigger-select register.
// Assumes synchronous inputs; priority and in-service logic live elsewhere.
module irq_req_latch
    import irq_req_latch_pkg::*;
#(
    parameter int unsigned NUM_LINES = DEF_LINES,
    parameter logic [NUM_LINES-1:0] WR_MASK = DEF_WR_MASK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic                 trig_wr,
    input  logic [NUM_LINES-1:0] trig_wdata,
    input  logic [NUM_LINES-1:0] ack,
    input  logic                 reinit,
    input  logic [NUM_LINES-1:0] line_mask,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] fresh,
    output logic [NUM_LINES-1:0] trig_sel
);

    logic [NUM_LINES-1:0] sel_w;

    // Trigger-select register instance.
    irq_trig_reg #(
        .NUM_LINES (NUM_LINES),
        .WR_MASK   (WR_MASK)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (trig_wr),
        .wdata (trig_wdata),
        .sel   (sel_w)
    );

    // One capture cell per request line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (sel_w[i]),
            .req        (req[i]),
            .ack        (ack[i]),
            .reinit     (reinit),
            .masked     (line_mask[i]),
            .pend       (pend[i]),
            .fresh      (fresh[i])
        );
    end

    assign trig_sel = sel_w;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && fresh == '0 && trig_sel == '0));

    // R6
    edge_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reinit && (ack & ~sel_w & ~req) != '0) |=> ((pend & $past(ack & ~sel_w & ~req)) == '0));

endmodule

// File: tb/tb_irq_req_latch.sv
// Scoreboard bench: the driver applies stimulus, predicts the registered
// outputs from the requirements and queues them; the monitor compares.
module tb_irq_req_latch;

    localparam int N = 8;
    localparam logic [N-1:0] MASK = 8'hF8;

    typedef struct {
        logic [N-1:0] pend;
        logic [N-1:0] fresh;
        logic [N-1:0] sel;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         trig_wr = 1'b0;
    logic [N-1:0] trig_wdata = '0;
    logic [N-1:0] ack = '0;
    logic         reinit = 1'b0;
    logic [N-1:0] line_mask = '0;
    logic [N-1:0] pend;
    logic [N-1:0] fresh;
    logic [N-1:0] trig_sel;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_sel = '0;

    irq_req_latch #(.NUM_LINES(N), .WR_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .trig_wr(trig_wr),
        .trig_wdata(trig_wdata), .ack(ack), .reinit(reinit),
        .line_mask(line_mask), .pend(pend), .fresh(fresh), .trig_sel(trig_sel)
    );

    always #2.5 clk = ~clk;

    // Compare one field and report a mismatch.
    task automatic cmp(input string tag, input string fld,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // Monitor: pops expectations at the falling edge after each update.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "pend", pend, e.pend);
                cmp(e.tag, "fresh", fresh, e.fresh);
                cmp(e.tag, "trig_sel", trig_sel, e.sel);
            end
        end
    end

    // Driver: one cycle of stimulus plus a predicted result.
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] a,
                        input logic ri, input logic w, input logic [N-1:0] wd,
                        input logic [N-1:0] mk, input string tag);
        logic [N-1:0] np, nv, nf, ns;
        exp_t e;
        @(negedge clk);
        req = r; ack = a; reinit = ri; trig_wr = w; trig_wdata = wd; line_mask = mk;
        for (int i = 0; i < N; i++) begin
            if (ri) begin
                np[i] = m_sel[i] & m_pend[i];
                nv[i] = 1'b0;
            end else if (m_sel[i]) begin
                np[i] = r[i];
                nv[i] = r[i];
            end else begin
                np[i] = (r[i] & ~m_prev[i]) | (m_pend[i] & ~a[i]);
                nv[i] = r[i];
            end
        end
        nf = np & ~m_pend & ~mk;
        ns = w ? (wd & MASK) : m_sel;
        m_pend = np; m_prev = nv; m_sel = ns;
        @(posedge clk);
        #1;
        e.pend = np; e.fresh = nf; e.sel = ns; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #1;
        e.pend = '0; e.fresh = '0; e.sel = '0; e.tag = "R1 reset";
        exp_q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: masked write; lines 0..2 edge, 3..7 level
        step('0, '0, 0, 1, 8'hFF, '0, "R2 masked write");
        // R11: no write keeps value
        step('0, '0, 0, 0, 8'h00, '0, "R11 hold");
        // R3: level lines follow input
        step(8'h18, '0, 0, 0, '0, '0, "R3 level set");
        step(8'h08, '0, 0, 0, '0, '0, "R3 level clear");
        // R4 / R9: rising edge on line 0
        step(8'h09, '0, 0, 0, '0, '0, "R4 R9 edge set");
        step(8'h09, '0, 0, 0, '0, '0, "R9 flag one cycle");
        // R6: ack clears while held high; R4: no re-set
        step(8'h09, 8'h01, 0, 0, '0, '0, "R6 ack clear");
        step(8'h09, '0, 0, 0, '0, '0, "R4 held high no reset");
        // R7: ack on level line 3
        step(8'h08, 8'h08, 0, 0, '0, '0, "R7 level ack ignored");
        // R5: fall after new rise keeps bit
        step(8'h08, '0, 0, 0, '0, '0, "R4 prep low");
        step(8'h09, '0, 0, 0, '0, '0, "R4 rise again");
        step(8'h08, '0, 0, 0, '0, '0, "R5 falling keeps");
        // R6: ack with simultaneous new edge
        step(8'h09, 8'h01, 0, 0, '0, '0, "R6 edge wins over ack");
        // R10: masked rise on line 1
        step(8'h0B, '0, 0, 0, '0, 8'h02, "R10 masked no flag");
        // R8: reinit with line 0 held high, line 3 level high
        step(8'h0B, '0, 1, 0, '0, '0, "R8 reinit");
        step(8'h0B, '0, 0, 0, '0, '0, "R8 edge after reinit");
        // R2: write another value
        step(8'h0B, '0, 0, 1, 8'h27, '0, "R2 second write");
        step(8'h00, '0, 0, 0, '0, '0, "R3 R11 after write");
        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_pend = '0; m_prev = '0; m_sel = '0;
        e.pend = '0; e.fresh = '0; e.sel = '0; e.tag = "R1 reset again";
        exp_q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule